// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block guesses, in the same cycle that a fetch address is presented, whether the instruction at that address is a taken branch and where it goes. It holds a direct-mapped table of `2^IDX_W` slots. Each slot keeps a valid flag, the complete address of the branch it describes, the last target seen for it and a 2-bit saturating confidence counter. The lookup is purely combinational, so its result can steer the next fetch address directly and a correct guess costs no bubble.

A later pipeline stage reports each resolved branch through an update port: the branch address, its real target and whether it was taken. The table learns from these reports on the next clock edge. A lookup and an update that touch the same slot in one cycle see the contents from before the update.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous active-high reset every slot is invalid, so every lookup returns not-taken with a target of fetch address + 4.
- R2: The slot is chosen by fetch address bits [IDX_W+1:2]; a lookup hits only when that slot is valid and its stored branch address equals the whole fetch address, so two addresses sharing a slot never hit on each other's entry.
- R3: The prediction is taken exactly when the lookup hits and bit 1 of the slot's counter is 1; a taken prediction carries the stored target, any other carries fetch address + 4, both in the same cycle as the fetch address.
- R4: An update that hits its slot moves the counter one step toward 3 when taken and toward 0 when not taken, saturating at both ends (0,1 = predict not taken; 2,3 = predict taken).
- R5: A taken update that misses its slot writes that slot with valid set, the branch address, the reported target and counter value 2, replacing whatever was there.
- R6: A not-taken update that misses its slot leaves the table unchanged.
- R7: An update that hits its slot replaces the stored target with the reported one.
- R8: An update becomes visible to lookups from the cycle after it is presented; a lookup in the same cycle returns the old contents.
- R9: While the update valid input is low, the other update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted taken branch at fetch_pc |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch report is present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Real target of the resolved branch |
| upd_taken | input | 1 | Resolved branch outcome |

## Verification
The embedded properties watch every cycle that a cleared table never predicts taken, that a taken miss installs the reported branch with a weakly-taken counter, that a not-taken miss leaves its slot untouched, and that a strongly-taken counter stays put on another taken report. Counter walks through all four states, aliasing between addresses that share a slot, same-cycle read-versus-write ordering and the masking by the valid input can only be shown by the bench's sequences, which compare each cycle's prediction against a reference table kept in the bench.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;
    typedef logic [1:0]      ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN = 2'd2;
    localparam ctr_t CTR_MAX        = 2'd3;

    // One table slot
    typedef struct packed {
        logic valid;
        pc_t  src;
        pc_t  tgt;
        ctr_t ctr;
    } btb_entry_t;

    // Resolved branch report
    typedef struct packed {
        logic valid;
        pc_t  pc;
        pc_t  tgt;
        logic taken;
    } btb_upd_t;

    // Lookup result
    typedef struct packed {
        logic taken;
        pc_t  target;
    } btb_pred_t;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        if (taken)
            return (c == CTR_MAX) ? c : c + 2'd1;
        else
            return (c == 2'd0) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output btb_entry_t       rd_entry,
    input  btb_upd_t         upd
);
    localparam int DEPTH = 1 << IDX_W;

    btb_entry_t       tbl [DEPTH];
    logic [IDX_W-1:0] widx;
    btb_entry_t       cur;
    btb_entry_t       wdata;
    logic             uhit;
    logic             wr_en;

    always_comb begin
        widx  = upd.pc[IDX_W+1:2];
        cur   = tbl[widx];
        uhit  = cur.valid && (cur.src == upd.pc);
        wr_en = upd.valid && (uhit || upd.taken);
        wdata.valid = 1'b1;
        wdata.src   = upd.pc;
        wdata.tgt   = upd.tgt;
        wdata.ctr   = uhit ? ctr_step(cur.ctr, upd.taken) : CTR_WEAK_TAKEN;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        btb_entry_t ent;
        always_ff @(posedge clk) begin
            if (rst)
                ent <= '0;
            else if (wr_en && (widx == IDX_W'(i)))
                ent <= wdata;
        end
        assign tbl[i] = ent;
    end

    assign rd_entry = tbl[rd_idx];

    // R5: taken miss installs the branch weakly taken
    a_r5_alloc_weak: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.taken && !uhit) |=>
            (tbl[$past(widx)].valid && tbl[$past(widx)].src == $past(upd.pc)
             && tbl[$past(widx)].tgt == $past(upd.tgt)
             && tbl[$past(widx)].ctr == CTR_WEAK_TAKEN));

    // R6: not-taken miss leaves the slot alone
    a_r6_nt_miss_keep: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && !upd.taken && !uhit) |=> (tbl[$past(widx)] == $past(cur)));

    // R4: counter saturates at the top
    a_r4_ctr_sat_top: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.taken && uhit && cur.ctr == CTR_MAX) |=>
            (tbl[$past(widx)].ctr == CTR_MAX));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pc_t              fetch_pc,
    output logic [IDX_W-1:0] rd_idx,
    input  btb_entry_t       rd_entry,
    output btb_pred_t        pred
);
    logic hit;

    assign rd_idx = fetch_pc[IDX_W+1:2];

    always_comb begin
        hit         = rd_entry.valid && (rd_entry.src == fetch_pc);
        pred.taken  = hit && rd_entry.ctr[1];
        pred.target = pred.taken ? rd_entry.tgt : fetch_pc + PC_W'(4);
    end

    // R1: the cycle after reset nothing is predicted taken
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred.taken);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    output logic        pred_taken,
    output logic [31:0] pred_target,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target,
    input  logic        upd_taken
);
    logic [IDX_W-1:0] rd_idx;
    btb_entry_t       rd_entry;
    btb_pred_t        pred;
    btb_upd_t         upd;

    assign upd = '{valid: upd_valid, pc: upd_pc, tgt: upd_target, taken: upd_taken};

    btb_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .upd      (upd)
    );

    btb_lookup #(.IDX_W(IDX_W)) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .fetch_pc (fetch_pc),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .pred     (pred)
    );

    assign pred_taken  = pred.taken;
    assign pred_target = pred.target;

endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference table
    bit          m_v   [DEPTH];
    logic [31:0] m_src [DEPTH];
    logic [31:0] m_tgt [DEPTH];
    int          m_ctr [DEPTH];

    always #2.5 clk = ~clk;

    btb_predictor #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken)
    );

    function automatic int slot(logic [31:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic [32:0] model_pred(logic [31:0] pc);
        int s = slot(pc);
        if (m_v[s] && m_src[s] == pc && m_ctr[s] >= 2)
            return {1'b1, m_tgt[s]};
        return {1'b0, pc + 32'd4};
    endfunction

    function automatic void model_upd(bit v, logic [31:0] pc, logic [31:0] t, bit tk);
        int s = slot(pc);
        if (!v) return;
        if (m_v[s] && m_src[s] == pc) begin
            m_tgt[s] = t;
            if (tk && m_ctr[s] < 3) m_ctr[s]++;
            if (!tk && m_ctr[s] > 0) m_ctr[s]--;
        end else if (tk) begin
            m_v[s] = 1; m_src[s] = pc; m_tgt[s] = t; m_ctr[s] = 2;
        end
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 0; m_ctr[i] = 0; m_src[i] = '0; m_tgt[i] = '0;
        end
    endfunction

    task automatic check(string req, logic [32:0] got, logic [32:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got taken=%0b tgt=%h expected taken=%0b tgt=%h",
                     req, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // One cycle: drive at negedge, compare before the edge, then advance model
    task automatic step(string req, logic [31:0] f, bit v, logic [31:0] p,
                        logic [31:0] t, bit tk);
        @(negedge clk);
        fetch_pc = f; upd_valid = v; upd_pc = p; upd_target = t; upd_taken = tk;
        #1;
        check(req, {pred_taken, pred_target}, model_pred(f));
        model_upd(v, p, t, tk);
    endtask

    task automatic look(string req, logic [31:0] f);
        step(req, f, 1'b0, 32'h0, 32'h0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] A     = 32'h0000_1040;
    localparam logic [31:0] ALIAS = A + (32'd1 << (IDX_W + 2));
    localparam logic [31:0] B     = 32'h0000_2008;

    initial begin
        logic [31:0] pool [24];
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset
        look("R1", A);
        look("R1", B);

        // R6: not-taken miss does nothing
        step("R6", A, 1, A, 32'h9000, 0);
        look("R6", A);

        // R5 + R8: taken miss allocates; same-cycle lookup sees old
        step("R8", A, 1, A, 32'h0000_4000, 1);
        look("R5", A);
        // R2: alias shares the slot but must not hit
        look("R2", ALIAS);

        // R4: 2 -> 1 predicts not taken; R7 target rewritten
        step("R4", A, 1, A, 32'h0000_4400, 0);
        look("R4", A);
        step("R4", A, 1, A, 32'h0000_4400, 0);   // 1 -> 0
        step("R4", A, 1, A, 32'h0000_4400, 0);   // stays 0
        step("R4", A, 1, A, 32'h0000_4800, 1);   // 0 -> 1
        look("R4", A);
        step("R7", A, 1, A, 32'h0000_4C00, 1);   // 1 -> 2
        look("R7", A);
        step("R4", A, 1, A, 32'h0000_4C00, 1);   // 3
        step("R4", A, 1, A, 32'h0000_4C00, 1);   // stays 3
        step("R4", A, 1, A, 32'h0000_4C00, 0);   // 2
        look("R4", A);

        // R9: invalid update is ignored
        step("R9", A, 0, A, 32'h0000_7777, 0);
        step("R9", A, 0, B, 32'h0000_7777, 1);
        look("R9", A);
        look("R9", B);

        // R5: taken alias replaces the slot
        step("R5", ALIAS, 1, ALIAS, 32'h0000_5000, 1);
        look("R5", ALIAS);
        look("R2", A);

        // R3: random traffic over an aliasing pool
        for (int i = 0; i < 24; i++)
            pool[i] = {16'h0, 4'($urandom_range(0, 3)), 10'($urandom_range(0, 15)) << 4, 2'b00}
                      + 32'(i % 4) * 32'h4;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f = pool[$urandom_range(0, 23)];
            logic [31:0] p = pool[$urandom_range(0, 23)];
            logic [31:0] t = {$urandom()} & 32'hFFFF_FFFC;
            step("R3", f, 1'($urandom_range(0, 3) != 0), p, t, 1'($urandom_range(0, 1)));
        end

        // R1: reset again clears learned state
        @(negedge clk); rst = 1'b1; model_reset();
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) look("R1", pool[i]);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule